// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a two-port shared memory of 2048 bytes and gives each port a doorbell. Two word locations at the top of the address space act as mailboxes. When one port writes a byte into the mailbox that belongs to the other port, the other port's active-low interrupt output goes low. The receiving port acknowledges by reading its own mailbox. That read returns the byte and releases the interrupt. No extra control registers are involved, so software on each side needs only ordinary loads and stores.

The left port's incoming mailbox is the second-highest address (0x7FE) and the right port's incoming mailbox is the highest address (0x7FF). Each port presents active-low chip enable, write enable and output enable strobes with an address and write data. These are sampled on the rising clock edge. The block keeps one pending bit and one byte of storage per mailbox, plus a registered read-data output per port for mailbox reads. All other storage of the shared memory lies outside this block.

Top module: `portmail_irq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, both interrupt outputs are high (inactive), both read-data outputs are 0x00, and both mailbox bytes are 0x00.
- R2: A valid write by the left port to address 0x7FF drives `rgt_irq_n` low from the next rising edge.
- R3: A valid read by the right port of address 0x7FF drives `rgt_irq_n` high from the next rising edge, unless R8 applies.
- R4: A valid write by the right port to address 0x7FE drives `lft_irq_n` low from the next rising edge.
- R5: A valid read by the left port of address 0x7FE drives `lft_irq_n` high from the next rising edge, unless R8 applies.
- R6: A valid write needs enable low and write strobe low. A valid read needs enable low, write strobe high and output enable low. Any other strobe combination has no effect on flags, mailbox bytes or read data.
- R7: A port writing its own incoming mailbox changes neither flag nor that mailbox byte. A port reading the other port's mailbox changes neither flag.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (low).
- R9: An acknowledging read puts the mailbox byte on that port's read-data output from the next rising edge. The byte is the one held before the edge, so a write in the same cycle is not seen.
- R10: A port reading the other port's mailbox gets that mailbox's current byte on its read-data output from the next rising edge.
- R11: Accesses to any non-mailbox address, and idle cycles, leave both flags and both read-data outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lft_en_n | input | 1 | Left port chip enable, active low |
| lft_wr_n | input | 1 | Left port write strobe, active low |
| lft_oe_n | input | 1 | Left port output enable, active low |
| lft_addr | input | 11 | Left port address |
| lft_wdata | input | 8 | Left port write data |
| rgt_en_n | input | 1 | Right port chip enable, active low |
| rgt_wr_n | input | 1 | Right port write strobe, active low |
| rgt_oe_n | input | 1 | Right port output enable, active low |
| rgt_addr | input | 11 | Right port address |
| rgt_wdata | input | 8 | Right port write data |
| lft_irq_n | output | 1 | Left port interrupt, active low |
| rgt_irq_n | output | 1 | Right port interrupt, active low |
| lft_rdata | output | 8 | Left port mailbox read data |
| rgt_rdata | output | 8 | Right port mailbox read data |

## Verification
On every cycle the assertions check flag setting and clearing on valid mailbox accesses, the priority of a set over a clear, and that flags and read data hold when no relevant access occurs. Only the bench's scenarios show the data path end to end: the byte returned by an acknowledge or a peek matches what the other side last wrote, a self-write to an incoming mailbox leaves the stored byte alone, and a same-cycle write and read returns the old byte. The bench also runs a long mixed sequence with biased random strobes against its reference model.

// File: rtl/portmail_pkg.sv
package portmail_pkg;

    localparam int NUM_SIDES = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_t;

    // Per-port decoded mailbox events
    typedef struct packed {
        logic send;   // valid write into the peer's mailbox
        logic ack;    // valid read of own incoming mailbox
        logic peek;   // valid read of the peer's mailbox
    } hit_t;

    function automatic acc_kind_t classify(input logic en_n,
                                           input logic wr_n,
                                           input logic oe_n);
        if (en_n)
            return ACC_NONE;
        if (!wr_n)
            return ACC_WRITE;
        if (!oe_n)
            return ACC_READ;
        return ACC_NONE;
    endfunction

endpackage

// File: rtl/portmail_decode.sv
module portmail_decode
    import portmail_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] IN_ADDR  = '1,
    parameter logic [ADDR_W-1:0] OUT_ADDR = '1
) (
    input  logic              en_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    acc_kind_t kind;
    logic      at_in;
    logic      at_out;

    always_comb begin
        kind     = classify(en_n, wr_n, oe_n);
        at_in    = (addr == IN_ADDR);
        at_out   = (addr == OUT_ADDR);
        hit.send = (kind == ACC_WRITE) && at_out;
        hit.ack  = (kind == ACC_READ)  && at_in;
        hit.peek = (kind == ACC_READ)  && at_out;
    end
endmodule

// File: rtl/portmail_flag.sv
module portmail_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (set_req)
            pending <= 1'b1;   // set has priority over clear
        else if (clr_req)
            pending <= 1'b0;
    end

    assign irq_n = ~pending;
endmodule

// File: rtl/portmail_slot.sv
module portmail_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (we)
            word <= wdata;
    end
endmodule

// File: rtl/portmail_irq.sv
module portmail_irq
    import portmail_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_en_n,
    input  logic              lft_wr_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    input  logic              rgt_en_n,
    input  logic              rgt_wr_n,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic              lft_irq_n,
    output logic              rgt_irq_n,
    output logic [DATA_W-1:0] lft_rdata,
    output logic [DATA_W-1:0] rgt_rdata
);
    // Right inbox is the top address, left inbox the one below it
    localparam logic [ADDR_W-1:0] RGT_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LFT_BOX = RGT_BOX - 1'b1;

    logic              en_n_a  [NUM_SIDES];
    logic              wr_n_a  [NUM_SIDES];
    logic              oe_n_a  [NUM_SIDES];
    logic [ADDR_W-1:0] addr_a  [NUM_SIDES];
    logic [DATA_W-1:0] wdata_a [NUM_SIDES];
    hit_t              hit_a   [NUM_SIDES];
    logic [DATA_W-1:0] inbox_a [NUM_SIDES];
    logic              irq_a   [NUM_SIDES];
    logic [DATA_W-1:0] rdata_a [NUM_SIDES];

    assign en_n_a[0]  = lft_en_n;
    assign wr_n_a[0]  = lft_wr_n;
    assign oe_n_a[0]  = lft_oe_n;
    assign addr_a[0]  = lft_addr;
    assign wdata_a[0] = lft_wdata;
    assign en_n_a[1]  = rgt_en_n;
    assign wr_n_a[1]  = rgt_wr_n;
    assign oe_n_a[1]  = rgt_oe_n;
    assign addr_a[1]  = rgt_addr;
    assign wdata_a[1] = rgt_wdata;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int PEER = NUM_SIDES - 1 - s;
        localparam logic [ADDR_W-1:0] IN_A  = (s == 0) ? LFT_BOX : RGT_BOX;
        localparam logic [ADDR_W-1:0] OUT_A = (s == 0) ? RGT_BOX : LFT_BOX;

        portmail_decode #(
            .ADDR_W  (ADDR_W),
            .IN_ADDR (IN_A),
            .OUT_ADDR(OUT_A)
        ) u_dec (
            .en_n(en_n_a[s]),
            .wr_n(wr_n_a[s]),
            .oe_n(oe_n_a[s]),
            .addr(addr_a[s]),
            .hit (hit_a[s])
        );

        portmail_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_req(hit_a[PEER].send),
            .clr_req(hit_a[s].ack),
            .irq_n  (irq_a[s])
        );

        // Inbox of this side: only the peer may fill it
        portmail_slot #(.DATA_W(DATA_W)) u_slot (
            .clk  (clk),
            .rst  (rst),
            .we   (hit_a[PEER].send),
            .wdata(wdata_a[PEER]),
            .word (inbox_a[s])
        );

        always_ff @(posedge clk) begin
            if (rst)
                rdata_a[s] <= '0;
            else if (hit_a[s].ack)
                rdata_a[s] <= inbox_a[s];
            else if (hit_a[s].peek)
                rdata_a[s] <= inbox_a[PEER];
        end
    end

    assign lft_irq_n = irq_a[0];
    assign rgt_irq_n = irq_a[1];
    assign lft_rdata = rdata_a[0];
    assign rgt_rdata = rdata_a[1];
endmodule

// File: rtl/portmail_irq_chk.sv
module portmail_irq_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lft_en_n,
    input logic              lft_wr_n,
    input logic              lft_oe_n,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              rgt_en_n,
    input logic              rgt_wr_n,
    input logic              rgt_oe_n,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              lft_irq_n,
    input logic              rgt_irq_n,
    input logic [DATA_W-1:0] lft_rdata,
    input logic [DATA_W-1:0] rgt_rdata
);
    localparam logic [ADDR_W-1:0] TOPA = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NXTA = TOPA - 1'b1;

    logic l_wr, l_rd, r_wr, r_rd;
    logic l_send, r_send, l_ack, r_ack, l_mbx_rd, r_mbx_rd;
    assign l_wr     = !lft_en_n && !lft_wr_n;
    assign l_rd     = !lft_en_n && lft_wr_n && !lft_oe_n;
    assign r_wr     = !rgt_en_n && !rgt_wr_n;
    assign r_rd     = !rgt_en_n && rgt_wr_n && !rgt_oe_n;
    assign l_send   = l_wr && (lft_addr == TOPA);
    assign r_send   = r_wr && (rgt_addr == NXTA);
    assign l_ack    = l_rd && (lft_addr == NXTA);
    assign r_ack    = r_rd && (rgt_addr == TOPA);
    assign l_mbx_rd = l_rd && (lft_addr == TOPA || lft_addr == NXTA);
    assign r_mbx_rd = r_rd && (rgt_addr == TOPA || rgt_addr == NXTA);

    p_reset_r1: assert property (@(posedge clk) rst |=> (lft_irq_n && rgt_irq_n));
    p_set_rgt_r2: assert property (@(posedge clk) disable iff (rst) l_send |=> !rgt_irq_n);
    p_clr_rgt_r3: assert property (@(posedge clk) disable iff (rst) (r_ack && !l_send) |=> rgt_irq_n);
    p_set_lft_r4: assert property (@(posedge clk) disable iff (rst) r_send |=> !lft_irq_n);
    p_clr_lft_r5: assert property (@(posedge clk) disable iff (rst) (l_ack && !r_send) |=> lft_irq_n);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst) (l_send && r_ack) |=> !rgt_irq_n);
    p_hold_rgt_r11: assert property (@(posedge clk) disable iff (rst) (!l_send && !r_ack) |=> $stable(rgt_irq_n));
    p_hold_lft_r11: assert property (@(posedge clk) disable iff (rst) (!r_send && !l_ack) |=> $stable(lft_irq_n));
    p_rdata_lft_r11: assert property (@(posedge clk) disable iff (rst) !l_mbx_rd |=> $stable(lft_rdata));
    p_rdata_rgt_r11: assert property (@(posedge clk) disable iff (rst) !r_mbx_rd |=> $stable(rgt_rdata));
endmodule

bind portmail_irq portmail_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lft_en_n (lft_en_n),
    .lft_wr_n (lft_wr_n),
    .lft_oe_n (lft_oe_n),
    .lft_addr (lft_addr),
    .rgt_en_n (rgt_en_n),
    .rgt_wr_n (rgt_wr_n),
    .rgt_oe_n (rgt_oe_n),
    .rgt_addr (rgt_addr),
    .lft_irq_n(lft_irq_n),
    .rgt_irq_n(rgt_irq_n),
    .lft_rdata(lft_rdata),
    .rgt_rdata(rgt_rdata)
);

// File: tb/tb_portmail_irq.sv
`timescale 1ns/1ps
module tb_portmail_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lft_en_n = 1'b1, lft_wr_n = 1'b1, lft_oe_n = 1'b1;
    logic [10:0] lft_addr = '0;
    logic [7:0]  lft_wdata = '0;
    logic       rgt_en_n = 1'b1, rgt_wr_n = 1'b1, rgt_oe_n = 1'b1;
    logic [10:0] rgt_addr = '0;
    logic [7:0]  rgt_wdata = '0;
    logic       lft_irq_n, rgt_irq_n;
    logic [7:0] lft_rdata, rgt_rdata;

    always #2 clk = ~clk;

    portmail_irq dut (
        .clk(clk), .rst(rst),
        .lft_en_n(lft_en_n), .lft_wr_n(lft_wr_n), .lft_oe_n(lft_oe_n),
        .lft_addr(lft_addr), .lft_wdata(lft_wdata),
        .rgt_en_n(rgt_en_n), .rgt_wr_n(rgt_wr_n), .rgt_oe_n(rgt_oe_n),
        .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n),
        .lft_rdata(lft_rdata), .rgt_rdata(rgt_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model: pending flags as plain bits, mailbox bytes, read data
    bit       m_lpend, m_rpend;
    int       m_lbox, m_rbox, m_ldat, m_rdat;

    always @(posedge clk) begin
        bit lw, lr, rw, rr;
        int nlb, nrb;
        if (rst) begin
            m_lpend = 0; m_rpend = 0;
            m_lbox = 0; m_rbox = 0; m_ldat = 0; m_rdat = 0;
        end else begin
            lw = !lft_en_n && !lft_wr_n;
            lr = !lft_en_n && lft_wr_n && !lft_oe_n;
            rw = !rgt_en_n && !rgt_wr_n;
            rr = !rgt_en_n && rgt_wr_n && !rgt_oe_n;
            if (lr && lft_addr == 11'h7FE) m_ldat = m_lbox;
            else if (lr && lft_addr == 11'h7FF) m_ldat = m_rbox;
            if (rr && rgt_addr == 11'h7FF) m_rdat = m_rbox;
            else if (rr && rgt_addr == 11'h7FE) m_rdat = m_lbox;
            nlb = m_lbox; nrb = m_rbox;
            if (lw && lft_addr == 11'h7FF) nrb = lft_wdata;
            if (rw && rgt_addr == 11'h7FE) nlb = rgt_wdata;
            if (lw && lft_addr == 11'h7FF) m_rpend = 1;
            else if (rr && rgt_addr == 11'h7FF) m_rpend = 0;
            if (rw && rgt_addr == 11'h7FE) m_lpend = 1;
            else if (lr && lft_addr == 11'h7FE) m_lpend = 0;
            m_lbox = nlb; m_rbox = nrb;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Pending stimulus, applied at the falling edge after checking outputs
    logic       p_le = 1, p_lw = 1, p_lo = 1, p_re = 1, p_rw = 1, p_ro = 1;
    logic [10:0] p_la = 0, p_ra = 0;
    logic [7:0]  p_ld = 0, p_rd = 0;
    string prev_tag = "R1";

    task automatic lset(logic e, logic w, logic o, logic [10:0] a, logic [7:0] d);
        p_le = e; p_lw = w; p_lo = o; p_la = a; p_ld = d;
    endtask
    task automatic rset(logic e, logic w, logic o, logic [10:0] a, logic [7:0] d);
        p_re = e; p_rw = w; p_ro = o; p_ra = a; p_rd = d;
    endtask

    task automatic tick(string tag);
        @(negedge clk);
        chk(prev_tag, "lft_irq_n", lft_irq_n, !m_lpend);
        chk(prev_tag, "rgt_irq_n", rgt_irq_n, !m_rpend);
        chk(prev_tag, "lft_rdata", lft_rdata, m_ldat);
        chk(prev_tag, "rgt_rdata", rgt_rdata, m_rdat);
        lft_en_n = p_le; lft_wr_n = p_lw; lft_oe_n = p_lo; lft_addr = p_la; lft_wdata = p_ld;
        rgt_en_n = p_re; rgt_wr_n = p_rw; rgt_oe_n = p_ro; rgt_addr = p_ra; rgt_wdata = p_rd;
        prev_tag = tag;
        lset(1, 1, 1, 0, 0);
        rset(1, 1, 1, 0, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "lft_irq_n rst", lft_irq_n, 1);
        chk("R1", "rgt_irq_n rst", rgt_irq_n, 1);
        chk("R1", "lft_rdata rst", lft_rdata, 0);
        rst = 1'b0;
        tick("R1");
        tick("R1");
        // R1: mailboxes empty after reset (peek both)
        lset(0, 1, 0, 11'h7FF, 0); rset(0, 1, 0, 11'h7FE, 0); tick("R1");
        tick("R1");
        chk("R1", "lft peek after rst", lft_rdata, 0);
        // R2: left sends to right
        lset(0, 0, 1, 11'h7FF, 8'hA5); tick("R2");
        tick("R2");
        chk("R2", "rgt_irq_n set", rgt_irq_n, 0);
        chk("R2", "lft_irq_n untouched", lft_irq_n, 1);
        // R3/R9: right acknowledges and gets the byte
        rset(0, 1, 0, 11'h7FF, 0); tick("R3");
        tick("R9");
        chk("R3", "rgt_irq_n clear", rgt_irq_n, 1);
        chk("R9", "rgt_rdata ack", rgt_rdata, 8'hA5);
        // R4/R5: right sends to left, left acknowledges
        rset(0, 0, 0, 11'h7FE, 8'h3C); tick("R4");
        tick("R4");
        chk("R4", "lft_irq_n set", lft_irq_n, 0);
        lset(0, 1, 0, 11'h7FE, 0); tick("R5");
        tick("R5");
        chk("R5", "lft_irq_n clear", lft_irq_n, 1);
        chk("R9", "lft_rdata ack", lft_rdata, 8'h3C);
        // R6: invalid strobes
        lset(1, 0, 1, 11'h7FF, 8'h11); tick("R6");
        tick("R6");
        chk("R6", "disabled write no set", rgt_irq_n, 1);
        lset(0, 0, 1, 11'h7FF, 8'h5A); tick("R6");
        rset(0, 1, 1, 11'h7FF, 0); tick("R6");
        rset(1, 1, 0, 11'h7FF, 0); tick("R6");
        tick("R6");
        chk("R6", "no-oe/no-en read keeps flag", rgt_irq_n, 0);
        chk("R6", "rgt_rdata unchanged", rgt_rdata, 8'hA5);
        // R7: right writes own inbox; left peeks right inbox (R10)
        rset(0, 0, 1, 11'h7FF, 8'h77); tick("R7");
        lset(0, 1, 0, 11'h7FF, 0); tick("R10");
        tick("R10");
        chk("R7", "self write keeps flag", rgt_irq_n, 0);
        chk("R10", "lft peek", lft_rdata, 8'h5A);
        chk("R7", "peek keeps flag", rgt_irq_n, 0);
        // R8: set and clear in same cycle; R9 read returns old byte
        lset(0, 0, 1, 11'h7FF, 8'hC3); rset(0, 1, 0, 11'h7FF, 0); tick("R8");
        tick("R8");
        chk("R8", "set wins", rgt_irq_n, 0);
        chk("R9", "same-cycle read old byte", rgt_rdata, 8'h5A);
        // R11: other addresses
        lset(0, 0, 1, 11'h123, 8'hFF); rset(0, 1, 0, 11'h7FD, 0); tick("R11");
        lset(0, 1, 0, 11'h000, 0); rset(0, 0, 1, 11'h3FE, 8'h01); tick("R11");
        tick("R11");
        chk("R11", "rgt flag held", rgt_irq_n, 0);
        chk("R11", "rgt_rdata held", rgt_rdata, 8'h5A);
        // Mixed traffic against the reference model
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: lset(0, 0, $urandom % 2, 11'h7FF, $urandom % 256);
                1: lset(0, 1, 0, 11'h7FE, 0);
                2: lset(0, 0, 1, 11'h7FE, $urandom % 256);
                3: lset(0, 1, 0, 11'h7FF, 0);
                4: lset($urandom % 2, $urandom % 2, $urandom % 2, 11'h7FE + ($urandom % 2), $urandom % 256);
                default: ;
            endcase
            op = $urandom % 6;
            case (op)
                0: rset(0, 0, $urandom % 2, 11'h7FE, $urandom % 256);
                1: rset(0, 1, 0, 11'h7FF, 0);
                2: rset(0, 0, 1, 11'h7FF, $urandom % 256);
                3: rset(0, 1, 0, 11'h7FE, 0);
                4: rset($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2048, $urandom % 256);
                default: ;
            endcase
            tick("R8");
        end
        tick("R11");
        done = 1;
        summary();
        $finish;
    end
endmodule